// File: doc/BRIEF.md
# Range-Aware Radix-4 Booth Multiplier

This block multiplies two signed 16-bit two's complement operands and returns the full 32-bit signed product. Partial products are formed by radix-4 Booth recoding of one of the two operands. A front end first measures how many bits of each operand carry information. It then steers the operand with the narrower range into the Booth recoder, and the other operand becomes the multiplicand. This makes zero digits more likely.

A strobe qualifies the operands. One clock later the product is available together with a one-cycle valid flag. Partial-product rows are kept in a bank of row registers. A row whose Booth digit lies outside the recoded operand's effective range is not reloaded: it keeps its old contents, and an active-row mask drops it from the sum. Between strobes the product does not move.

Top module: `range_booth_mul`

## Requirements
- R1: For every pair of operands accepted with `in_valid` high, `product` equals the signed product of `op_a` and `op_b`, exact in 32 bits, on the cycle after the strobe.
- R2: `out_valid` is high exactly on the cycle after a cycle with `in_valid` high and low otherwise; after reset `out_valid` is 0 and `product` is 0.
- R3: The effective range of an operand is its width minus the count of redundant leading copies of the sign bit. Values 0 and -1 have range 1, values 1 and -2 have range 2, and -32768 and 32767 have range 16.
- R4: While `in_valid` stays low, `product` holds the last result unchanged.
- R5: The operand with the strictly smaller effective range is Booth-recoded. When the two ranges are equal, `op_b` is recoded.
- R6: Booth digit j is taken from recoded bits (2j+1, 2j, 2j-1), with bit -1 read as 0. The windows map as follows: 000 and 111 to 0, 001 and 010 to +1, 011 to +2, 100 to -2, and 101 and 110 to -1. A negative digit forms its row as the bitwise inverse of the sign-extended multiple, plus a one at bit 2j.
- R7: Row j is active when 2j is less than the recoded operand's range. An inactive row register keeps its previous contents across a strobe and contributes nothing to the product.
- R8: The most negative value is handled exactly: -32768 times -32768 gives 0x40000000, and -32768 times 32767 gives 0xC0008000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 16 | First signed operand |
| op_b | input | 16 | Second signed operand |
| out_valid | output | 1 | High for one cycle when a new product is presented |
| product | output | 32 | Signed product, held between strobes |

## Verification
Every pair drawn from a set of signed corner values is applied: powers of two, their negatives, and all-ones masks. This exposes errors in sign extension, in the inversion-plus-one correction, and in the most negative value. An exhaustive sweep of both operands over -64..63 covers every mix of short ranges, including equal-range ties and operands whose range shrinks from one strobe to the next. That sweep separates a correct row mask from stale rows leaking into the sum. Random full-width pairs exercise all eight rows with mixed digits. Idle gaps after a result show whether the output holds and whether the valid flag pulses only once.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [2:0] {
    BD_ZERO = 3'd0,
    BD_P1   = 3'd1,
    BD_P2   = 3'd2,
    BD_M1   = 3'd3,
    BD_M2   = 3'd4
  } booth_dig_e;

  function automatic booth_dig_e booth_decode(input logic [2:0] win);
    booth_dig_e d;
    case (win)
      3'b001, 3'b010: d = BD_P1;
      3'b011:         d = BD_P2;
      3'b100:         d = BD_M2;
      3'b101, 3'b110: d = BD_M1;
      default:        d = BD_ZERO;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mul_range_meter.sv
module mul_range_meter #(
  parameter int W  = 16,
  parameter int RW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [RW-1:0] range
);

  always_comb begin
    range = RW'(1);
    for (int i = 0; i < W - 1; i++) begin
      if (value[i] != value[W-1]) begin
        range = RW'(i + 2);
      end
    end
  end

endmodule

// File: rtl/mul_booth_row.sv
module mul_booth_row
  import mul_pkg::*;
#(
  parameter int W   = 16,
  parameter int IDX = 0,
  parameter int PW  = 2 * W
) (
  input  logic [2:0]    win,
  input  logic [W-1:0]  mcand,
  output logic [PW-1:0] row,
  output logic          neg
);

  booth_dig_e      dig;
  logic [W:0]      mult;
  logic [PW-1:0]   ext;

  assign dig = booth_decode(win);

  always_comb begin
    mult = '0;
    neg  = 1'b0;
    case (dig)
      BD_P1: mult = {mcand[W-1], mcand};
      BD_P2: mult = {mcand, 1'b0};
      BD_M1: begin
        mult = {mcand[W-1], mcand};
        neg  = 1'b1;
      end
      BD_M2: begin
        mult = {mcand, 1'b0};
        neg  = 1'b1;
      end
      default: mult = '0;
    endcase
  end

  always_comb begin
    ext = {{(PW-W-1){mult[W]}}, mult};
    if (neg) begin
      ext = ~ext;
    end
    row = ext << (2 * IDX);
  end

endmodule

// File: rtl/mul_adder_tree.sv
module mul_adder_tree #(
  parameter int W = 32,
  parameter int N = 9
) (
  input  logic [W-1:0] terms [N],
  output logic [W-1:0] sum
);

  localparam int L  = (N > 1) ? $clog2(N) : 1;
  localparam int NP = 1 << L;

  for (genvar l = 0; l <= L; l++) begin : g_lvl
    localparam int CNT = NP >> l;
    logic [W-1:0] v [CNT];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < NP; i++) begin : g_in
        if (i < N) begin : g_used
          assign v[i] = terms[i];
        end else begin : g_pad
          assign v[i] = '0;
        end
      end
    end else begin : g_add
      for (genvar i = 0; i < CNT; i++) begin : g_node
        assign v[i] = g_lvl[l-1].v[2*i] + g_lvl[l-1].v[2*i+1];
      end
    end
  end

  assign sum = g_lvl[L].v[0];

endmodule

// File: rtl/range_booth_mul.sv
module range_booth_mul #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic            out_valid,
  output logic [2*W-1:0]  product
);

  localparam int PW   = 2 * W;
  localparam int NDIG = W / 2;
  localparam int RW   = $clog2(W + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // range measurement and steering
  logic [RW-1:0] rng_a, rng_b, rng_rec;
  logic          sel_b;
  logic [W-1:0]  rec_op, mcand;
  logic [W:0]    rec_ext;

  mul_range_meter #(.W(W), .RW(RW)) u_rng_a (.value(op_a), .range(rng_a));
  mul_range_meter #(.W(W), .RW(RW)) u_rng_b (.value(op_b), .range(rng_b));

  always_comb begin
    sel_b   = !(rng_a < rng_b);
    rec_op  = sel_b ? op_b  : op_a;
    mcand   = sel_b ? op_a  : op_b;
    rng_rec = sel_b ? rng_b : rng_a;
    rec_ext = {rec_op, 1'b0};
  end

  logic [NDIG-1:0] act;
  always_comb begin
    for (int j = 0; j < NDIG; j++) begin
      act[j] = ((2 * j) < int'(rng_rec));
    end
  end

  // partial-product rows
  logic [NDIG-1:0][PW-1:0] row_d, row_q, row_n;
  logic [NDIG-1:0]         neg_d, neg_q, neg_n;
  logic [NDIG-1:0]         row_ld;

  for (genvar j = 0; j < NDIG; j++) begin : g_row
    mul_booth_row #(.W(W), .IDX(j), .PW(PW)) u_row (
      .win   (rec_ext[2*j+2:2*j]),
      .mcand (mcand),
      .row   (row_d[j]),
      .neg   (neg_d[j])
    );
  end

  assign row_ld = {NDIG{in_valid}} & act;

  always_comb begin
    row_n = row_q;
    neg_n = neg_q;
    for (int j = 0; j < NDIG; j++) begin
      if (row_ld[j]) begin
        row_n[j] = row_d[j];
        neg_n[j] = neg_d[j];
      end
    end
  end

  logic [NDIG-1:0] mask_q, mask_n;
  logic            vld_q, vld_n;

  always_comb begin
    mask_n = in_valid ? act : mask_q;
    vld_n  = in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      row_q  <= '0;
      neg_q  <= '0;
      mask_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      row_q  <= row_n;
      neg_q  <= neg_n;
      mask_q <= mask_n;
      vld_q  <= vld_n;
    end
  end

  // summation of active rows plus negation corrections
  logic [PW-1:0] terms [NDIG+1];
  logic [PW-1:0] corr;

  always_comb begin
    corr = '0;
    for (int j = 0; j < NDIG; j++) begin
      terms[j] = mask_q[j] ? row_q[j] : '0;
      corr[2*j] = neg_q[j] & mask_q[j];
    end
    terms[NDIG] = corr;
  end

  mul_adder_tree #(.W(PW), .N(NDIG + 1)) u_tree (
    .terms (terms),
    .sum   (product)
  );

  assign out_valid = vld_q;

endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
  parameter int W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic [W-1:0]                  op_a,
  input logic [W-1:0]                  op_b,
  input logic                          out_valid,
  input logic [2*W-1:0]                product,
  input logic [$clog2(W+1)-1:0]        rng_a,
  input logic [$clog2(W+1)-1:0]        rng_b,
  input logic                          sel_b,
  input logic [W/2-1:0]                act,
  input logic [W/2-1:0][2*W-1:0]       row_q
);

  localparam int PW = 2 * W;

  logic signed [PW-1:0] ref_prod;
  assign ref_prod = PW'(signed'(op_a)) * PW'(signed'(op_b));

  // R1: one-cycle latency and exact product
  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (product == $past(ref_prod)));

  // R2: valid pulse follows strobe only
  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4: output held between strobes
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  // R5: narrower operand recoded, tie picks op_b
  p_steer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (sel_b ? (rng_b <= rng_a) : (rng_a < rng_b)));

  // R7: active rows form a prefix starting at row 0
  p_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (act[0] && $onehot0(act + 1'b1)));

  for (genvar j = 0; j < W / 2; j++) begin : g_gate
    // R7: gated rows keep contents
    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !act[j]) |=> $stable(row_q[j]));
  end

endmodule

bind range_booth_mul rbm_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .product   (product),
  .rng_a     (rng_a),
  .rng_b     (rng_b),
  .sel_b     (sel_b),
  .act       (act),
  .row_q     (row_q)
);

// File: tb/range_booth_mul_test.sv
module range_booth_mul_test;

  localparam int W  = 16;
  localparam int PW = 32;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  op_a, op_b;
  logic          out_valid;
  logic [PW-1:0] product;

  int n_tests;
  int n_fail;

  range_booth_mul #(.W(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int eff_range(input logic [W-1:0] v);
    int r = 1;
    for (int i = 0; i < W - 1; i++) if (v[i] != v[W-1]) r = i + 2;
    return r;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    longint ref_p;
    op_a = a;
    op_b = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ref_p = longint'(signed'(a)) * longint'(signed'(b));
    check(req, product, ref_p[PW-1:0]);
    check("R2 valid pulse", {31'd0, out_valid}, 32'd1);
  endtask

  logic [W-1:0] cv [48];

  initial begin
    n_tests  = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op_a     = '0;
    op_b     = '0;
    for (int k = 0; k < 16; k++) begin
      cv[3*k]   = W'(1 << k);
      cv[3*k+1] = W'(-(1 << k));
      cv[3*k+2] = W'((1 << k) - 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    check("R2 reset valid", {31'd0, out_valid}, 32'd0);
    check("R2 reset product", product, 32'd0);

    // R3: range helper sanity on known values
    check("R3 range 0", 32'(eff_range(16'h0000)), 32'd1);
    check("R3 range -1", 32'(eff_range(16'hFFFF)), 32'd1);
    check("R3 range -32768", 32'(eff_range(16'h8000)), 32'd16);

    // R8: extremes
    mul(16'h8000, 16'h8000, "R8 min*min");
    check("R8 min*min literal", product, 32'h4000_0000);
    mul(16'h8000, 16'h7FFF, "R8 min*max");
    check("R8 min*max literal", product, 32'hC000_8000);
    mul(16'h7FFF, 16'h7FFF, "R8 max*max");

    // R4: hold while idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 hold", product, 32'h3FFF_0001);
      check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    end

    // R1 R6: all corner pairs
    for (int i = 0; i < 48; i++)
      for (int j = 0; j < 48; j++)
        mul(cv[i], cv[j], "R1 R6 corner pair");

    // R3 R5 R7: exhaustive short-range sweep (ties and shrinking ranges)
    for (int a = -64; a < 64; a++)
      for (int b = -64; b < 64; b++)
        mul(W'(a), W'(b),
            (eff_range(W'(a)) == eff_range(W'(b))) ? "R5 tie" : "R3 R7 short range");

    // R7: wide result then narrow operands must not leak stale rows
    mul(16'h9234, 16'hA5A5, "R7 wide");
    mul(16'h0003, 16'hFFFE, "R7 narrow after wide");
    @(negedge clk);
    check("R4 hold narrow", product, 32'hFFFF_FFFA);

    // R1 R6: random full-width pairs
    for (int i = 0; i < 3000; i++)
      mul(W'($urandom), W'($urandom), "R1 R6 random");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule